// File: doc/BRIEF.md
# Colour Subcarrier Phase Synthesizer with Field-Sequence Realignment

This block produces the running colour subcarrier phase for a composite video encoder. A 32-bit accumulator adds a programmable frequency word on every pixel clock on which `pix_en` is high, and wraps modulo 2^32. The top bits of `phase` are meant to address a sine table further down the chain. That table and any analog output lie outside this block.

A field counter advances on each `fld_start` strobe. It counts through a four-field colour sequence for NTSC (`std_pal` = 0) and an eight-field sequence for PAL (`std_pal` = 1). Two mode bits decide when the phase is forced back to zero, which keeps small clock errors from piling up:
- **Sequence mode** (`mode_a` = 0): the phase is cleared when the sequence rolls over to field 0.
- **Request mode** (`mode_a` = 1, `mode_b` = 0): the phase runs freely. A pulse on `phs_req` clears the phase and the field index at the next field start.
- **Free-run mode** (`mode_a` = 1, `mode_b` = 1): nothing clears the phase, so the output follows unstable source timing.

The phase stream has no back-pressure. `phase` is a registered value that moves on every enabled clock, and a consumer must take it on the clock it appears. `pix_en` acts as the upstream valid and has no matching ready. Control pins are plain levels or single-cycle pulses.

Top module: `scph_dds`

## Requirements
- R1: After reset `phase` is 0, `field_idx` is 0, and the frequency word is 0x21F07C16. The first enabled clock after reset therefore gives a phase of 0x21F07C16.
- R2: On a clock with `pix_en` = 1 and no clear, `phase` becomes the old phase plus the frequency word, modulo 2^32. With `pix_en` = 0 and no clear, `phase` holds.
- R3: A frequency write (`freq_wr` = 1) loads `freq_data`. The new word is used from the next clock on, and the clock of the write still adds the old word.
- R4: With `std_pal` = 0, each `fld_start` advances `field_idx` by one and wraps from 3 to 0. Without `fld_start` the index holds.
- R5: With `std_pal` = 1, `field_idx` runs 0 to 7 and wraps from 7 to 0.
- R6: With `mode_a` = 0, a `fld_start` while `field_idx` is at the last field of the sequence clears `phase` to exactly 0 on that same clock, whatever `pix_en` is. Other field starts do not clear it.
- R7: With `mode_a` = 1 and `mode_b` = 0, no sequence rollover clears the phase. A `phs_req` pulse is held, and at the next `fld_start` it clears `phase` to 0 and sets `field_idx` to 0 on that clock. A request arriving on the same clock as a `fld_start` waits for the following one.
- R8: With `mode_a` = 1 and `mode_b` = 1, `phase` is never cleared: neither rollover nor `phs_req` clears it. With `mode_a` = 0, `phs_req` has no effect on `phase` or `field_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Advance the accumulator this clock (upstream valid) |
| fld_start | input | 1 | Single-cycle strobe at the start of each field |
| std_pal | input | 1 | 0: four-field NTSC sequence, 1: eight-field PAL sequence |
| mode_a | input | 1 | 0: sequence realignment; 1: realignment only by request or never |
| mode_b | input | 1 | With mode_a = 1: 0 honours requests, 1 free-runs |
| phs_req | input | 1 | Pulse requesting realignment at the next field start |
| freq_wr | input | 1 | Load freq_data into the frequency word |
| freq_data | input | 32 | New frequency word |
| phase | output | 32 | Accumulated subcarrier phase |
| field_idx | output | 3 | Current field within the colour sequence |

## Verification
The properties take for granted that `fld_start` is a single-cycle strobe, and that `std_pal`, `mode_a` and `mode_b` change only between fields, never on a strobe clock. A field index left beyond the NTSC range by a switch from PAL falls back to 0 at the next strobe, and no property covers that transition. The stimulus sets the standard and the mode only while the index is 0 or the switch is harmless. It pulses the strobe for exactly one clock, and it places requests both between strobes and on a strobe clock.

// File: rtl/scph_pkg.sv
package scph_pkg;

  // Realignment policy derived from the two mode pins.
  typedef enum logic [1:0] {
    RA_SEQUENCE = 2'd0,  // clear at every sequence rollover
    RA_REQUEST  = 2'd1,  // clear only on a held request
    RA_FREE     = 2'd2   // never clear
  } realign_t;

  function automatic realign_t decode_realign(input logic a, input logic b);
    if (!a)     return RA_SEQUENCE;
    else if (!b) return RA_REQUEST;
    else        return RA_FREE;
  endfunction

endpackage

// File: rtl/scph_freq_reg.sv
module scph_freq_reg #(
  parameter int unsigned      W       = 32,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] freq
);

  always_ff @(posedge clk) begin
    if (!rst_n)     freq <= RST_VAL;
    else if (wr_en) freq <= wr_data;
  end

endmodule

// File: rtl/scph_field_seq.sv
module scph_field_seq
  import scph_pkg::*;
#(
  parameter int unsigned NTSC_FIELDS = 4,
  parameter int unsigned PAL_FIELDS  = 8,
  localparam int unsigned FLD_W      = $clog2(PAL_FIELDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_start,
  input  logic             std_pal,
  input  realign_t         policy,
  input  logic             phs_req,
  output logic [FLD_W-1:0] field_idx,
  output logic             clr_phase
);

  localparam logic [FLD_W-1:0] NTSC_LAST = FLD_W'(NTSC_FIELDS - 1);
  localparam logic [FLD_W-1:0] PAL_LAST  = FLD_W'(PAL_FIELDS - 1);

  logic [FLD_W-1:0] last_idx;
  logic             at_last;
  logic             pend_q;
  logic             req_hit;
  logic             auto_hit;

  assign last_idx = std_pal ? PAL_LAST : NTSC_LAST;
  assign at_last  = (field_idx >= last_idx);
  assign req_hit  = fld_start && (policy == RA_REQUEST) && pend_q;
  assign auto_hit = fld_start && (policy == RA_SEQUENCE) && at_last;
  assign clr_phase = req_hit || auto_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_idx <= '0;
      pend_q    <= 1'b0;
    end else if (fld_start) begin
      field_idx <= (req_hit || at_last) ? '0 : field_idx + 1'b1;
      pend_q    <= phs_req;
    end else begin
      pend_q    <= pend_q || phs_req;
    end
  end

endmodule

// File: rtl/scph_phase_acc.sv
module scph_phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] freq,
  output logic [W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else if (adv) phase <= phase + freq;
  end

endmodule

// File: rtl/scph_dds.sv
module scph_dds
  import scph_pkg::*;
#(
  parameter int unsigned         PHASE_W     = 32,
  parameter logic [PHASE_W-1:0]  FREQ_RESET  = 32'h21F0_7C16,
  parameter int unsigned         NTSC_FIELDS = 4,
  parameter int unsigned         PAL_FIELDS  = 8,
  localparam int unsigned        FLD_W       = $clog2(PAL_FIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               fld_start,
  input  logic               std_pal,
  input  logic               mode_a,
  input  logic               mode_b,
  input  logic               phs_req,
  input  logic               freq_wr,
  input  logic [PHASE_W-1:0] freq_data,
  output logic [PHASE_W-1:0] phase,
  output logic [FLD_W-1:0]   field_idx
);

  logic [PHASE_W-1:0] freq_q;
  logic               clr_phase;
  realign_t           policy;

  assign policy = decode_realign(mode_a, mode_b);

  scph_freq_reg #(.W(PHASE_W), .RST_VAL(FREQ_RESET)) u_freq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (freq_wr),
    .wr_data (freq_data),
    .freq    (freq_q)
  );

  scph_field_seq #(.NTSC_FIELDS(NTSC_FIELDS), .PAL_FIELDS(PAL_FIELDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld_start (fld_start),
    .std_pal   (std_pal),
    .policy    (policy),
    .phs_req   (phs_req),
    .field_idx (field_idx),
    .clr_phase (clr_phase)
  );

  scph_phase_acc #(.W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pix_en),
    .clr   (clr_phase),
    .freq  (freq_q),
    .phase (phase)
  );

endmodule

// File: rtl/scph_dds_chk.sv
module scph_dds_chk #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned FLD_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_en,
  input logic               fld_start,
  input logic               std_pal,
  input logic               mode_a,
  input logic               mode_b,
  input logic [PHASE_W-1:0] freq,
  input logic [PHASE_W-1:0] phase,
  input logic [FLD_W-1:0]   field_idx
);

  // R2: idle clock holds the phase
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !fld_start) |=> $stable(phase));

  // R2: enabled clock away from a field start adds the word
  p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !fld_start) |=> (phase == $past(phase) + $past(freq)));

  // R4: index moves only on a strobe
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_start |=> $stable(field_idx));

  // R4: NTSC wrap
  p_ntsc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && !std_pal && field_idx == 3) |=> (field_idx == 0));

  // R5: PAL wrap
  p_pal_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && std_pal && field_idx == 7) |=> (field_idx == 0));

  // R6: rollover in sequence mode realigns the phase
  p_auto_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && !mode_a && field_idx == (std_pal ? 7 : 3)) |=> (phase == 0));

  // R8: free-run never clears
  p_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && mode_a && mode_b && pix_en) |=> (phase == $past(phase) + $past(freq)));

endmodule

bind scph_dds scph_dds_chk #(.PHASE_W(PHASE_W), .FLD_W(FLD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_en    (pix_en),
  .fld_start (fld_start),
  .std_pal   (std_pal),
  .mode_a    (mode_a),
  .mode_b    (mode_b),
  .freq      (freq_q),
  .phase     (phase),
  .field_idx (field_idx)
);

// File: tb/scph_dds_test.sv
module scph_dds_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0, fld_start = 1'b0, std_pal = 1'b0;
  logic        mode_a = 1'b0, mode_b = 1'b0, phs_req = 1'b0, freq_wr = 1'b0;
  logic [31:0] freq_data = '0;
  logic [31:0] phase;
  logic [2:0]  field_idx;

  always #5 clk = ~clk;

  scph_dds uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .fld_start(fld_start),
    .std_pal(std_pal), .mode_a(mode_a), .mode_b(mode_b), .phs_req(phs_req),
    .freq_wr(freq_wr), .freq_data(freq_data), .phase(phase), .field_idx(field_idx)
  );

  typedef struct {
    logic [31:0] ph;
    logic [2:0]  fi;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_phase = '0, m_freq = 32'h21F0_7C16;
  logic [2:0]  m_field = '0;
  logic        m_pend = 1'b0;

  task automatic compare(input logic [31:0] ph, input logic [2:0] fi, input exp_t e);
    checks++;
    if (ph !== e.ph || fi !== e.fi) begin
      errors++;
      $display("FAIL %s: phase=%h field=%0d expected phase=%h field=%0d",
               e.tag, ph, fi, e.ph, e.fi);
    end
  endtask

  task automatic cfg(input logic pal, input logic a, input logic b);
    @(negedge clk);
    std_pal = pal; mode_a = a; mode_b = b;
    pix_en = 0; fld_start = 0; phs_req = 0; freq_wr = 0;
  endtask

  // driver: applies one clock of stimulus and queues the expected outcome
  task automatic step(input logic pe, input logic fs, input logic rq,
                      input logic wr, input logic [31:0] d, input string tag);
    exp_t e;
    logic [2:0] last;
    logic auto_c, req_c;
    @(negedge clk);
    pix_en = pe; fld_start = fs; phs_req = rq; freq_wr = wr; freq_data = d;
    last   = std_pal ? 3'd7 : 3'd3;
    auto_c = fs && !mode_a && (m_field >= last);
    req_c  = fs && mode_a && !mode_b && m_pend;
    if (auto_c || req_c) m_phase = '0;
    else if (pe)         m_phase = m_phase + m_freq;
    if (fs) begin
      m_field = (req_c || m_field >= last) ? 3'd0 : m_field + 3'd1;
      m_pend  = rq;
    end else begin
      m_pend  = m_pend | rq;
    end
    if (wr) m_freq = d;
    @(posedge clk);
    e.ph = m_phase; e.fi = m_field; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) compare(phase, field_idx, exp_q.pop_front());
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    begin
      exp_t e0;
      e0.ph = '0; e0.fi = '0; e0.tag = "R1 reset state";
      @(negedge clk);
      compare(phase, field_idx, e0);
    end
    step(1, 0, 0, 0, 0, "R1 default word");
    step(0, 0, 0, 0, 0, "R2 hold");
    step(1, 0, 0, 0, 0, "R2 add");
    step(1, 0, 0, 0, 0, "R2 add");
    step(1, 0, 0, 1, 32'hFFFF_0000, "R3 write uses old word");
    step(1, 0, 0, 0, 0, "R3 new word");
    step(1, 0, 0, 0, 0, "R2 wrap");
    step(0, 0, 0, 0, 0, "R2 hold");
    step(1, 0, 0, 1, 32'h0123_4567, "R3 reload");
    // NTSC sequence mode
    for (int f = 0; f < 5; f++) begin
      step(1, 1, 0, 0, 0, "R4 R6 ntsc field start");
      step(1, 0, 0, 0, 0, "R2 in field");
    end
    // drive to field 3 then rollover with pix_en low
    while (m_field != 3'd3) step(1, 1, 0, 0, 0, "R4 advance");
    step(0, 1, 0, 0, 0, "R6 clear without pix_en");
    step(1, 0, 0, 0, 0, "R6 restart");
    // PAL sequence mode
    cfg(1, 0, 0);
    for (int f = 0; f < 9; f++) begin
      step(1, 1, 0, 0, 0, "R5 R6 pal field start");
      step(1, 0, 1, 0, 0, "R8 request ignored in sequence mode");
    end
    // request mode, PAL
    while (m_field != 3'd0) step(1, 1, 0, 0, 0, "R5 align");
    cfg(1, 1, 0);
    for (int f = 0; f < 10; f++) begin
      step(1, 1, 0, 0, 0, "R7 rollover no clear");
      step(1, 0, 0, 0, 0, "R7 running");
    end
    while (m_field != 3'd5) step(1, 1, 0, 0, 0, "R7 to field 5");
    step(1, 0, 1, 0, 0, "R7 request in field 5");
    step(1, 0, 0, 0, 0, "R7 held");
    step(1, 1, 0, 0, 0, "R7 realign at field start");
    step(1, 0, 0, 0, 0, "R7 after realign");
    step(1, 1, 1, 0, 0, "R7 request on strobe");
    step(1, 0, 0, 0, 0, "R7 not yet");
    step(1, 1, 0, 0, 0, "R7 deferred realign");
    // NTSC request mode
    cfg(0, 1, 0);
    for (int f = 0; f < 6; f++) step(1, 1, 0, 0, 0, "R4 R7 ntsc no auto clear");
    // free-run
    cfg(0, 1, 1);
    for (int f = 0; f < 6; f++) begin
      step(1, 0, 1, 0, 0, "R8 free request");
      step(1, 1, 0, 0, 0, "R8 free field start");
    end
    step(0, 0, 0, 0, 0, "R2 hold");
    step(0, 0, 0, 0, 0, "R4 no strobe hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule